// File: doc/BRIEF.md
# Timer Interrupt Edge-to-Pending Converter

This block sits between a bank of per-core timers and watchdogs and a multi-core interrupt controller. Each timer and each watchdog drives a level interrupt line. The converter watches those lines and turns every low-to-high transition into a single-cycle request. The request tells the controller to mark one private interrupt as pending for one core. A line that stays high raises nothing further; only a fresh rising transition counts.

The source lines are grouped in pairs, one pair per core. The even member of a pair is the timer and the odd member is the watchdog. The target core is therefore the source index with its low bit dropped, and the interrupt number is 29 for a timer and 30 for a watchdog. When several lines rise in the same cycle, the rises are held in a small set of pending flags. They are then handed out one per cycle, lowest source index first, so none is lost. Slots that belong to cores that are not present are ignored.

Top module: `tmr_edge_pend`

## Requirements
- R1: While reset is held, and in any cycle without a request, `set_pend` is 0 and both `tgt_core` and `irq_id` read 0. All stored previous levels reset to low, so a line that is already high when reset is released produces one request.
- R2: A request is raised only for a source whose level is high while its stored previous level is low. A line held high for many cycles produces no further request, and with all lines low and nothing queued no request appears.
- R3: The stored previous level of every source follows its input on every clock, whether or not a request for it is queued or being issued. A high-low-high sequence on one line therefore gives two requests.
- R4: `tgt_core` equals the index of the served source shifted right by one bit.
- R5: `irq_id` is 29 when the served source index is even (timer) and 30 when it is odd (watchdog).
- R6: Rises seen in the same cycle are issued on consecutive cycles in ascending source index, one per cycle, with none dropped.
- R7: Source slots with index at or above 2 × `NUM_CORES` never produce a request, whatever their level.
- R8: A request becomes visible in the cycle that follows the clock edge that first samples the high level. For a lone edge it lasts exactly one cycle.
- R9: A rise on a lower-indexed source that arrives while higher-indexed rises are still queued is served before them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl | input | 2*MAX_CORES | Level interrupt lines; index 2c is core c's timer, 2c+1 its watchdog |
| set_pend | output | 1 | One-cycle request to set a private interrupt pending |
| tgt_core | output | clog2(MAX_CORES) | Core that the request is aimed at |
| irq_id | output | 5 | Interrupt number of the request (29 timer, 30 watchdog) |

## Verification
Two functions can fall in the same cycle. One is the issue of a queued request, which clears that source's pending flag. The other is the capture of a brand-new rise, which may belong to a lower-indexed source. The bench provokes this by raising two high-indexed lines together. Just after the first of them is served, it raises source 0. The order of the following requests is then compared against the ascending-index rule, and the bench checks that the second queued source is neither lost nor issued twice.

// File: rtl/tmr_edge_pend_pkg.sv
package tmr_edge_pend_pkg;

   localparam int unsigned SRC_PER_CORE = 2;
   localparam int unsigned ID_W         = 5;

   localparam logic [ID_W-1:0] ID_TIMER = 5'd29;
   localparam logic [ID_W-1:0] ID_WDOG  = 5'd30;

   // kind = low bit of the source index: 0 timer, 1 watchdog
   function automatic logic [ID_W-1:0] id_of(input logic kind);
      return kind ? ID_WDOG : ID_TIMER;
   endfunction

endpackage

// File: rtl/tmr_edge_bank.sv
module tmr_edge_bank #(
   parameter int unsigned N_SLOTS = 8,
   parameter int unsigned N_WIRED = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_SLOTS-1:0] lvl,
   output logic [N_SLOTS-1:0] rise
);

   generate
      for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
         if (g < N_WIRED) begin : g_live
            logic prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) prev_q <= 1'b0;
               else        prev_q <= lvl[g];
            end
            assign rise[g] = lvl[g] & ~prev_q;
         end else begin : g_dead
            assign rise[g] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/tmr_pend_queue.sv
module tmr_pend_queue #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] pend
);

   logic [N-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

   assign pend = pend_q;

endmodule

// File: rtl/tmr_low_pick.sv
module tmr_low_pick #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3,
   parameter int unsigned STYLE = 0
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     grant
);

   assign any = |req;

   generate
      if (STYLE == 0) begin : g_scan
         always_comb begin
            idx   = '0;
            grant = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) begin
                  idx      = IDX_W'(i);
                  grant    = '0;
                  grant[i] = 1'b1;
               end
            end
         end
      end else begin : g_isolate
         logic [N-1:0] iso;
         assign iso   = req & (~req + N'(1));
         assign grant = iso;
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (iso[i]) idx = idx | IDX_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tmr_edge_pend.sv
module tmr_edge_pend
   import tmr_edge_pend_pkg::*;
#(
   parameter int unsigned NUM_CORES  = 4,
   parameter int unsigned MAX_CORES  = 4,
   parameter int unsigned PICK_STYLE = 0,
   localparam int unsigned SLOTS     = MAX_CORES * SRC_PER_CORE,
   localparam int unsigned CORE_W    = $clog2(MAX_CORES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOTS-1:0]  src_lvl,
   output logic              set_pend,
   output logic [CORE_W-1:0] tgt_core,
   output logic [ID_W-1:0]   irq_id
);

   localparam int unsigned SRC_W   = $clog2(SLOTS);
   localparam int unsigned N_WIRED = NUM_CORES * SRC_PER_CORE;

   generate
      if (MAX_CORES < 2) begin : g_bad_max
         $error("tmr_edge_pend: MAX_CORES must be at least 2");
      end
      if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_num
         $error("tmr_edge_pend: NUM_CORES out of range");
      end
      if (PICK_STYLE > 1) begin : g_bad_style
         $error("tmr_edge_pend: PICK_STYLE must be 0 or 1");
      end
   endgenerate

   logic [SLOTS-1:0] rise;
   logic [SLOTS-1:0] pend;
   logic [SLOTS-1:0] grant;
   logic             any;
   logic [SRC_W-1:0] idx;

   tmr_edge_bank #(
      .N_SLOTS (SLOTS),
      .N_WIRED (N_WIRED)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (src_lvl),
      .rise  (rise)
   );

   tmr_pend_queue #(
      .N (SLOTS)
   ) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (rise),
      .clr_vec (grant),
      .pend    (pend)
   );

   tmr_low_pick #(
      .N     (SLOTS),
      .IDX_W (SRC_W),
      .STYLE (PICK_STYLE)
   ) u_pick (
      .req   (pend),
      .any   (any),
      .idx   (idx),
      .grant (grant)
   );

   assign set_pend = any;
   assign tgt_core = any ? idx[SRC_W-1:1] : '0;
   assign irq_id   = any ? id_of(idx[0]) : '0;

endmodule

// File: rtl/tmr_edge_pend_chk.sv
module tmr_edge_pend_chk
   import tmr_edge_pend_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned MAX_CORES = 4,
   localparam int unsigned SLOTS    = MAX_CORES * SRC_PER_CORE,
   localparam int unsigned CORE_W   = $clog2(MAX_CORES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SLOTS-1:0]  src_lvl,
   input logic              set_pend,
   input logic [CORE_W-1:0] tgt_core,
   input logic [ID_W-1:0]   irq_id
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !set_pend |-> (tgt_core == '0 && irq_id == '0)); // R1

   AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_pend && src_lvl == '0) |=> !set_pend); // R2

   AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      set_pend |-> (irq_id == ID_TIMER || irq_id == ID_WDOG)); // R5

   AST_CORE_WIRED: assert property (@(posedge clk) disable iff (!rst_n)
      set_pend |-> ({1'b0, tgt_core} < (CORE_W + 1)'(NUM_CORES))); // R7

   AST_SRC0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && src_lvl[0] && !$past(src_lvl[0]))
      |=> (set_pend && tgt_core == '0 && irq_id == ID_TIMER)); // R6

endmodule

bind tmr_edge_pend tmr_edge_pend_chk #(
   .NUM_CORES (NUM_CORES),
   .MAX_CORES (MAX_CORES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_lvl  (src_lvl),
   .set_pend (set_pend),
   .tgt_core (tgt_core),
   .irq_id   (irq_id)
);

// File: tb/tb_tmr_edge_pend.sv
module tb_tmr_edge_pend;

   localparam int CLK_PERIOD = 10;

   logic       clk;
   logic       rst_n;
   logic [7:0] src;
   logic       set_pend;
   logic [1:0] tgt_core;
   logic [4:0] irq_id;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   tmr_edge_pend #(
      .NUM_CORES  (3),
      .MAX_CORES  (4),
      .PICK_STYLE (0)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_lvl  (src),
      .set_pend (set_pend),
      .tgt_core (tgt_core),
      .irq_id   (irq_id)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int id_for(input int s);
      return (s % 2 == 1) ? 30 : 29;
   endfunction

   task automatic expect_out(input logic v, input int core, input int id, input string tag);
      checks++;
      if (set_pend !== v || tgt_core !== 2'(core) || irq_id !== 5'(id)) begin
         errors++;
         $display("FAIL %s: got vld=%0b core=%0d id=%0d, expected vld=%0b core=%0d id=%0d",
                  tag, set_pend, tgt_core, irq_id, v, core, id);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      src   = 8'h02;
      repeat (3) @(negedge clk);
      expect_out(1'b0, 0, 0, "R1 outputs idle in reset");
      rst_n = 1'b1;
      @(negedge clk);
      expect_out(1'b1, 0, 30, "R1 stored level reset low");
      @(negedge clk);
      expect_out(1'b0, 0, 0, "R2 held line no repeat");
      src = 8'h00;
      @(negedge clk);
      expect_out(1'b0, 0, 0, "R1 idle after drop");
   endtask

   task automatic t_single();
      for (int s = 0; s < 6; s++) begin
         @(negedge clk);
         src = 8'(1 << s);
         @(negedge clk);
         expect_out(1'b1, s / 2, id_for(s), "R4 R5 R8 single edge");
         @(negedge clk);
         expect_out(1'b0, 0, 0, "R8 one-cycle strobe");
         src = 8'h00;
      end
   endtask

   task automatic t_held();
      @(negedge clk);
      src = 8'h10;
      @(negedge clk);
      expect_out(1'b1, 2, 29, "R2 first edge");
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         expect_out(1'b0, 0, 0, "R2 held high quiet");
      end
      src = 8'h00;
   endtask

   task automatic t_pulse();
      @(negedge clk);
      src = 8'h04;
      @(negedge clk);
      expect_out(1'b1, 1, 29, "R3 first rise");
      src = 8'h00;
      @(negedge clk);
      expect_out(1'b0, 0, 0, "R3 low gap");
      src = 8'h04;
      @(negedge clk);
      expect_out(1'b1, 1, 29, "R3 second rise");
      src = 8'h00;
   endtask

   task automatic t_burst();
      @(negedge clk);
      src = 8'hFF;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         expect_out(1'b1, k / 2, id_for(k), "R6 ascending drain");
      end
      @(negedge clk);
      expect_out(1'b0, 0, 0, "R7 unwired slots silent after drain");
      src = 8'h00;
   endtask

   task automatic t_dead();
      @(negedge clk);
      src = 8'hC0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         expect_out(1'b0, 0, 0, "R7 unwired slots ignored");
      end
      src = 8'h00;
   endtask

   task automatic t_overtake();
      @(negedge clk);
      src = 8'h28;
      @(negedge clk);
      expect_out(1'b1, 1, 30, "R6 lower of pair first");
      src = 8'h29;
      @(negedge clk);
      expect_out(1'b1, 0, 29, "R9 new low index overtakes");
      @(negedge clk);
      expect_out(1'b1, 2, 30, "R9 queued source kept");
      @(negedge clk);
      expect_out(1'b0, 0, 0, "R6 no duplicate");
      src = 8'h00;
   endtask

   initial begin
      t_reset();
      t_single();
      t_held();
      t_pulse();
      t_burst();
      t_dead();
      t_overtake();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: got run still active, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule